// File: doc/BRIEF.md
# Scrambled Register Hub with Interrupt Aggregation

This block is a small memory-mapped hub of sixteen 16-bit registers. It sits between a host bus and a handful of peripherals: four input ports, a sound-side handshake pair, a security-unit read path and a 512-word sound FIFO. After reset the register offsets decode linearly. One exact data value written to register 0 switches on a fixed offset permutation. From then on, every host offset is first passed through a 16-entry map supplied on an input, and the permutation stays on until the next reset.

The hub rebuilds its interrupt status word every cycle from live conditions: the FIFO being empty and the two sound handshake flags. It masks that word with an enable register that has a global enable in bit 0, and drives one registered interrupt line. Bit 2 of the sound control register takes the FIFO out of reset. The host reads the FIFO level flags and the handshake flags through the sound status register. A producer pushes words into the FIFO and a consumer pops them on dedicated strobes.

Top module: `scrambled_io_hub`

## Requirements
- R1: After reset the permutation is off, the interrupt enable register (offset 15) reads 0, the sound control register (offset 8) is 0, the handshake bits start at output-empty (status bit 7 set, bit 6 clear) and `irq_o` is 0.
- R2: A bus write of exactly 0x00E2 that lands on register 0 (after any translation) turns the permutation on, clears register 15 and register 4, and the permutation stays on until reset.
- R3: While the permutation is on, every access at bus offset o reaches register `perm_map[4*o+3:4*o]`. While it is off, offset o reaches register o.
- R4: Registers 0..3 read input port i from `in_ports[16*i+15:16*i]`. While the permutation is off, register 0 reads the port with bit 0 forced to 1 and bits 15:13 forced to 3'b001. While it is on, register 0 returns the port unmodified.
- R5: Register 14 reads 0x2000 OR 0x0080 (when `snd_in_empty` is 1) OR 0x0040 (when `snd_out_full` is 1) OR 0x0008 (when the FIFO is empty), with bit 0 set whenever any other bit is set. The handshake inputs pass through one register stage. Writes to register 14 have no effect.
- R6: `irq_o` is a register. It is 1 in the cycle after one in which enable bit 0 is 1 and (status AND enable AND 0x3FFE) is nonzero, and 0 otherwise.
- R7: The FIFO holds 512 16-bit words in first-in, first-out order. A push while full is dropped. A pop while empty is dropped and leaves `fifo_pop_data` unchanged. Popped data appears on `fifo_pop_data` after the clock edge that takes the pop.
- R8: Register 10 reads FIFO-empty in bit 3, at-least-256 entries in bit 4, 512 entries in bit 5, `snd_out_full` in bit 6 and `snd_in_empty` in bit 7, with all other bits zero.
- R9: While bit 2 of register 8 is 0, the FIFO count and pointers are held at zero and pushes are dropped.
- R10: Register 13 reads `sec_rd_data` in bits 7:0 and `sec_rd_status` in bit 8, with bits 15:9 zero.
- R11: Every other register (4..7, 8, 9, 11, 12, 15) stores the bus write and reads back the stored value.
- R12: `bus_rdata` is registered. It takes the addressed value at the clock edge that samples `bus_rd` and holds when `bus_rd` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register offset before translation |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| perm_map | input | 64 | Permutation map, entry i in bits 4i+3:4i |
| in_ports | input | 64 | Four input port words, port i in bits 16i+15:16i |
| snd_out_full | input | 1 | Sound side has data waiting for the host |
| snd_in_empty | input | 1 | Sound side input buffer is empty |
| sec_rd_data | input | 8 | Security unit data byte |
| sec_rd_status | input | 1 | Security unit data-ready status |
| fifo_push | input | 1 | FIFO write strobe |
| fifo_push_data | input | 16 | FIFO write word |
| fifo_pop | input | 1 | FIFO read strobe |
| fifo_pop_data | output | 16 | Last word popped from the FIFO |
| irq_o | output | 1 | Registered interrupt request |

## Verification
On every cycle, the assertions check the following: the unlock write turns the permutation on and clears the enable register, the permutation never turns off again, the interrupt stays low whenever the global enable or every source enable is clear, the FIFO count never passes the depth, the full flag implies the half flag, and a held FIFO is empty one cycle later. Only the bench scenarios show the rest. These are the read compositions of registers 0, 10, 13 and 14, the exact words and order the FIFO returns across a full fill and drain, and the dropped push and pop at the two ends. They also cover the one-cycle interrupt latency after an enable write and the offset remapping through the example map after unlock.

// File: rtl/hub_pkg.sv
package hub_pkg;
  localparam int DW = 16;

  localparam int REG_PORT0   = 0;
  localparam int REG_SCRATCH = 4;
  localparam int REG_SNDCTL  = 8;
  localparam int REG_SNDSTAT = 10;
  localparam int REG_SECIN   = 13;
  localparam int REG_INTSTAT = 14;
  localparam int REG_INTEN   = 15;

  localparam int FIFO_RUN_BIT = 2;

  localparam logic [DW-1:0] UNLOCK_CODE  = 16'h00E2;
  localparam logic [DW-1:0] INTSTAT_BASE = 16'h2000;
  localparam logic [DW-1:0] IRQ_SRC_MASK = 16'h3FFE;
endpackage

// File: rtl/hub_addr_xlate.sv
module hub_addr_xlate #(
  parameter int ADDR_W = 4
) (
  input  logic                          perm_on,
  input  logic [ADDR_W-1:0]             raw_addr,
  input  logic [(1<<ADDR_W)*ADDR_W-1:0] map_flat,
  output logic [ADDR_W-1:0]             phys_addr
);
  localparam int NENT = 1 << ADDR_W;

  logic [ADDR_W-1:0] map_ent [NENT];

  for (genvar g = 0; g < NENT; g++) begin : g_unpack
    assign map_ent[g] = map_flat[g*ADDR_W +: ADDR_W];
  end

  assign phys_addr = perm_on ? map_ent[raw_addr] : raw_addr;
endmodule

// File: rtl/hub_sound_fifo.sv
module hub_sound_fifo #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 512
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       hold,
  input  logic                       push,
  input  logic [WIDTH-1:0]           push_data,
  input  logic                       pop,
  output logic [WIDTH-1:0]           pop_data,
  output logic [$clog2(DEPTH):0]     count,
  output logic                       empty,
  output logic                       half,
  output logic                       full
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wr_ptr, rd_ptr;
  logic             do_push, do_pop;

  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));
  assign half  = (count >= CW'(DEPTH / 2));

  assign do_push = push && !hold && !full;
  assign do_pop  = pop  && !hold && !empty;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // storage and synchronous read port, no reset: maps to block RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
    if (do_pop)  pop_data    <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/hub_irq_ctrl.sv
module hub_irq_ctrl
  import hub_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          snd_out_full,
  input  logic          snd_in_empty,
  input  logic          fifo_empty,
  input  logic [DW-1:0] int_en,
  output logic [1:0]    hs_bits,
  output logic [DW-1:0] int_stat,
  output logic          irq_q
);
  logic [DW-1:0] raw_stat;

  // hs_bits[1] = input empty, hs_bits[0] = output full
  always_ff @(posedge clk) begin
    if (rst) hs_bits <= 2'b10;
    else     hs_bits <= {snd_in_empty, snd_out_full};
  end

  always_comb begin
    raw_stat    = INTSTAT_BASE;
    raw_stat[7] = hs_bits[1];
    raw_stat[6] = hs_bits[0];
    raw_stat[3] = fifo_empty;
    int_stat    = raw_stat;
    int_stat[0] = |raw_stat[DW-1:1];
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= int_en[0] && |(int_stat & int_en & IRQ_SRC_MASK);
  end
endmodule

// File: rtl/scrambled_io_hub.sv
module scrambled_io_hub
  import hub_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int NUM_PORTS  = 4,
  parameter int FIFO_DEPTH = 512
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            bus_wr,
  input  logic                            bus_rd,
  input  logic [ADDR_W-1:0]               bus_addr,
  input  logic [DW-1:0]                   bus_wdata,
  output logic [DW-1:0]                   bus_rdata,
  input  logic [(1<<ADDR_W)*ADDR_W-1:0]   perm_map,
  input  logic [NUM_PORTS*DW-1:0]         in_ports,
  input  logic                            snd_out_full,
  input  logic                            snd_in_empty,
  input  logic [7:0]                      sec_rd_data,
  input  logic                            sec_rd_status,
  input  logic                            fifo_push,
  input  logic [DW-1:0]                   fifo_push_data,
  input  logic                            fifo_pop,
  output logic [DW-1:0]                   fifo_pop_data,
  output logic                            irq_o
);
  localparam int NREG   = 1 << ADDR_W;
  localparam int PORT_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
  localparam int CNT_W  = $clog2(FIFO_DEPTH) + 1;

  logic [ADDR_W-1:0] phys_addr;
  logic              perm_on_q;
  logic [DW-1:0]     regs_q [NREG];
  logic [DW-1:0]     port_word [NUM_PORTS];
  logic [DW-1:0]     int_en, snd_ctl, int_stat, rd_val;
  logic [1:0]        hs_bits;
  logic              unlock_hit;
  logic [CNT_W-1:0]  fifo_count;
  logic              fifo_empty, fifo_half, fifo_full;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_ports
    assign port_word[p] = in_ports[p*DW +: DW];
  end

  hub_addr_xlate #(.ADDR_W(ADDR_W)) u_xlate (
    .perm_on   (perm_on_q),
    .raw_addr  (bus_addr),
    .map_flat  (perm_map),
    .phys_addr (phys_addr)
  );

  assign int_en  = regs_q[REG_INTEN];
  assign snd_ctl = regs_q[REG_SNDCTL];

  assign unlock_hit = bus_wr && (phys_addr == ADDR_W'(REG_PORT0))
                      && (bus_wdata == UNLOCK_CODE);

  // register file and unlock state
  always_ff @(posedge clk) begin
    if (rst) begin
      perm_on_q <= 1'b0;
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else if (bus_wr) begin
      if (unlock_hit) begin
        perm_on_q           <= 1'b1;
        regs_q[REG_PORT0]   <= bus_wdata;
        regs_q[REG_INTEN]   <= '0;
        regs_q[REG_SCRATCH] <= '0;
      end else if (phys_addr != ADDR_W'(REG_INTSTAT)) begin
        regs_q[phys_addr] <= bus_wdata;
      end
    end
  end

  hub_sound_fifo #(.WIDTH(DW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .hold      (!snd_ctl[FIFO_RUN_BIT]),
    .push      (fifo_push),
    .push_data (fifo_push_data),
    .pop       (fifo_pop),
    .pop_data  (fifo_pop_data),
    .count     (fifo_count),
    .empty     (fifo_empty),
    .half      (fifo_half),
    .full      (fifo_full)
  );

  hub_irq_ctrl u_irq (
    .clk          (clk),
    .rst          (rst),
    .snd_out_full (snd_out_full),
    .snd_in_empty (snd_in_empty),
    .fifo_empty   (fifo_empty),
    .int_en       (int_en),
    .hs_bits      (hs_bits),
    .int_stat     (int_stat),
    .irq_q        (irq_o)
  );

  // read composition
  always_comb begin
    rd_val = regs_q[phys_addr];
    if (phys_addr < ADDR_W'(NUM_PORTS)) begin
      rd_val = port_word[phys_addr[PORT_W-1:0]];
      if (phys_addr == ADDR_W'(REG_PORT0) && !perm_on_q)
        rd_val = {3'b001, port_word[0][12:1], 1'b1};
    end else if (phys_addr == ADDR_W'(REG_INTSTAT)) begin
      rd_val = int_stat;
    end else if (phys_addr == ADDR_W'(REG_SNDSTAT)) begin
      rd_val = {8'h00, hs_bits, fifo_full, fifo_half, fifo_empty, 3'b000};
    end else if (phys_addr == ADDR_W'(REG_SECIN)) begin
      rd_val = {7'b0, sec_rd_status, sec_rd_data};
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_val;
  end
endmodule

// File: rtl/hub_checker.sv
module hub_checker
  import hub_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DEPTH  = 512,
  parameter int CNT_W  = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] phys_addr,
  input logic [DW-1:0]     bus_wdata,
  input logic              perm_on,
  input logic [DW-1:0]     int_en,
  input logic [DW-1:0]     snd_ctl,
  input logic              irq_o,
  input logic [CNT_W-1:0]  fifo_count,
  input logic              fifo_full,
  input logic              fifo_half,
  input logic              fifo_empty
);
  assert_unlock_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && phys_addr == '0 && bus_wdata == UNLOCK_CODE) |=> (perm_on && int_en == '0));

  assert_perm_sticky_R2: assert property (@(posedge clk) disable iff (rst)
    perm_on |=> perm_on);

  assert_irq_global_gate_R6: assert property (@(posedge clk) disable iff (rst)
    !int_en[0] |=> !irq_o);

  assert_irq_src_gate_R6: assert property (@(posedge clk) disable iff (rst)
    ((int_en & IRQ_SRC_MASK) == '0) |=> !irq_o);

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    fifo_count <= CNT_W'(DEPTH));

  assert_flag_order_R8: assert property (@(posedge clk) disable iff (rst)
    fifo_full |-> (fifo_half && !fifo_empty));

  assert_hold_empty_R9: assert property (@(posedge clk) disable iff (rst)
    !snd_ctl[FIFO_RUN_BIT] |=> (fifo_count == '0));
endmodule

bind scrambled_io_hub hub_checker #(
  .ADDR_W (ADDR_W),
  .DEPTH  (FIFO_DEPTH),
  .CNT_W  (CNT_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_wr     (bus_wr),
  .phys_addr  (phys_addr),
  .bus_wdata  (bus_wdata),
  .perm_on    (perm_on_q),
  .int_en     (int_en),
  .snd_ctl    (snd_ctl),
  .irq_o      (irq_o),
  .fifo_count (fifo_count),
  .fifo_full  (fifo_full),
  .fifo_half  (fifo_half),
  .fifo_empty (fifo_empty)
);

// File: tb/tb_scrambled_io_hub.sv
module tb_scrambled_io_hub;
  logic        clk = 1'b0;
  logic        rst;
  logic        bus_wr = 0, bus_rd = 0;
  logic [3:0]  bus_addr = 0;
  logic [15:0] bus_wdata = 0, bus_rdata;
  logic [63:0] perm_map, in_ports = 0;
  logic        snd_out_full = 0, snd_in_empty = 1;
  logic [7:0]  sec_rd_data = 0;
  logic        sec_rd_status = 0;
  logic        fifo_push = 0, fifo_pop = 0;
  logic [15:0] fifo_push_data = 0, fifo_pop_data;
  logic        irq_o;

  int n_checks = 0, n_fail = 0;
  bit done = 0;
  bit m_perm = 0;
  logic [15:0] m_regs [16];
  logic [15:0] q [$];
  logic [15:0] v, last_pop;
  int unsigned seed;

  localparam logic [3:0] EX_MAP [16] = '{4'h4, 4'h5, 4'h6, 4'h7, 4'hB, 4'hA, 4'h9, 4'h8,
                                          4'h3, 4'h2, 4'h1, 4'h0, 4'hF, 4'hE, 4'hD, 4'hC};

  always #2.5 clk = ~clk;

  scrambled_io_hub dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .perm_map(perm_map), .in_ports(in_ports),
    .snd_out_full(snd_out_full), .snd_in_empty(snd_in_empty), .sec_rd_data(sec_rd_data),
    .sec_rd_status(sec_rd_status), .fifo_push(fifo_push), .fifo_push_data(fifo_push_data),
    .fifo_pop(fifo_pop), .fifo_pop_data(fifo_pop_data), .irq_o(irq_o));

  function automatic logic [3:0] to_bus(input logic [3:0] p);
    if (!m_perm) return p;
    for (int i = 0; i < 16; i++) if (EX_MAP[i] == p) return 4'(i);
    return p;
  endfunction

  function automatic logic [15:0] exp_stat(input logic of, input logic ie, input logic em);
    return 16'h2001 | (16'(ie) << 7) | (16'(of) << 6) | (16'(em) << 3);
  endfunction

  function automatic logic [15:0] exp_snd(input logic of, input logic ie, input int cnt);
    return (16'(ie) << 7) | (16'(of) << 6) | (16'(cnt == 512) << 5)
         | (16'(cnt >= 256) << 4) | (16'(cnt == 0) << 3);
  endfunction

  function automatic logic exp_irq(input logic [15:0] en, input logic of, input logic ie, input logic em);
    return en[0] && ((exp_stat(of, ie, em) & en & 16'h3FFE) != 0);
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] phys, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = to_bus(phys); bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [3:0] phys, output logic [15:0] d);
    @(negedge clk);
    bus_rd = 1; bus_addr = to_bus(phys);
    @(negedge clk);
    bus_rd = 0;
    d = bus_rdata;
  endtask

  task automatic push(input logic [15:0] d);
    @(negedge clk);
    fifo_push = 1; fifo_push_data = d;
    @(negedge clk);
    fifo_push = 0;
  endtask

  task automatic pop(output logic [15:0] d);
    @(negedge clk);
    fifo_pop = 1;
    @(negedge clk);
    fifo_pop = 0;
    d = fifo_pop_data;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    seed = 32'h1234_5678;
    void'($urandom(seed));
    for (int i = 0; i < 16; i++) perm_map[i*4 +: 4] = EX_MAP[i];
    for (int i = 0; i < 16; i++) m_regs[i] = 0;
    rst = 1;
    repeat (4) @(negedge clk);
    rst = 0;

    // R1 reset state
    chk("R1 irq after reset", 16'(irq_o), 16'h0);
    rd(4'hE, v); chk("R1 status after reset", v, 16'h2089);
    rd(4'hF, v); chk("R1 enable after reset", v, 16'h0);
    rd(4'h8, v); chk("R1 sound control after reset", v, 16'h0);
    rd(4'hA, v); chk("R8 sound status after reset", v, 16'h0088);

    // R4 port reads, linear decode
    for (int k = 0; k < 8; k++) begin
      in_ports = {$urandom, $urandom};
      rd(4'h0, v); chk("R4 port0 forced bits", v, (in_ports[15:0] & 16'h1FFE) | 16'h2001);
      for (int p = 1; p < 4; p++) begin
        rd(4'(p), v); chk("R4 port read", v, in_ports[p*16 +: 16]);
      end
    end

    // R11 store/readback
    for (int k = 0; k < 24; k++) begin
      logic [3:0] a;
      logic [15:0] d;
      case ($urandom % 6)
        0: a = 4'h4; 1: a = 4'h5; 2: a = 4'h6; 3: a = 4'h9; 4: a = 4'hB; default: a = 4'hC;
      endcase
      d = 16'($urandom);
      wr(a, d); m_regs[a] = d;
      rd(a, v); chk("R11 readback", v, m_regs[a]);
    end

    // R10 security read
    for (int k = 0; k < 5; k++) begin
      sec_rd_data = 8'($urandom); sec_rd_status = 1'($urandom);
      rd(4'hD, v); chk("R10 security word", v, {7'b0, sec_rd_status, sec_rd_data});
    end

    // R5 status composition, writes ignored
    wr(4'hE, 16'hFFFF);
    snd_out_full = 1; snd_in_empty = 0; settle();
    rd(4'hE, v); chk("R5 status out_full", v, exp_stat(1, 0, 1));
    rd(4'hA, v); chk("R8 handshake bits", v, exp_snd(1, 0, 0));
    snd_out_full = 0; snd_in_empty = 0; settle();
    rd(4'hE, v); chk("R5 status no handshake", v, exp_stat(0, 0, 1));

    // R9 held FIFO drops pushes
    push(16'hAAAA); push(16'h5555); settle();
    rd(4'hA, v); chk("R9 held FIFO empty", v, exp_snd(0, 0, 0));

    // R6 gating and latency
    wr(4'hF, 16'h0008); settle(); chk("R6 no global enable", 16'(irq_o), 16'h0);
    wr(4'hF, 16'h0001); settle(); chk("R6 bit0 alone", 16'(irq_o), 16'h0);
    @(negedge clk); bus_wr = 1; bus_addr = to_bus(4'hF); bus_wdata = 16'h0009;
    @(negedge clk); bus_wr = 0; chk("R6 one cycle before irq", 16'(irq_o), 16'h0);
    @(negedge clk); chk("R6 irq on fifo empty", 16'(irq_o), 16'(exp_irq(16'h0009, 0, 0, 1)));
    wr(4'hF, 16'h2001); settle(); chk("R6 always-set source", 16'(irq_o), 16'h1);
    wr(4'hF, 16'h0081); snd_in_empty = 1; settle();
    chk("R6 input empty source", 16'(irq_o), 16'h1);
    snd_in_empty = 0; settle(); chk("R6 source removed", 16'(irq_o), 16'h0);

    // R7 / R8 fill and drain
    wr(4'h8, 16'h0004); m_regs[8] = 16'h0004;
    wr(4'hF, 16'h0009);
    for (int k = 0; k < 255; k++) begin
      v = 16'($urandom); push(v); q.push_back(v);
    end
    settle();
    rd(4'hA, v); chk("R8 255 entries", v, exp_snd(0, 0, 255));
    chk("R6 irq clear when not empty", 16'(irq_o), 16'h0);
    v = 16'h1357; push(v); q.push_back(v);
    rd(4'hA, v); chk("R8 half at 256", v, exp_snd(0, 0, 256));
    for (int k = 0; k < 256; k++) begin
      v = 16'($urandom); push(v); q.push_back(v);
    end
    rd(4'hA, v); chk("R8 full at 512", v, exp_snd(0, 0, 512));
    push(16'hDEAD);
    for (int k = 0; k < 512; k++) begin
      logic [15:0] e;
      pop(v); e = q.pop_front();
      chk("R7 FIFO order", v, e);
    end
    last_pop = v;
    pop(v); chk("R7 pop on empty ignored", v, last_pop);
    settle();
    rd(4'hA, v); chk("R8 empty after drain", v, exp_snd(0, 0, 0));
    chk("R6 irq on drain", 16'(irq_o), 16'h1);

    // R9 hold clears contents
    push(16'h0F0F); push(16'hF0F0);
    wr(4'h8, 16'h0000); settle();
    rd(4'hA, v); chk("R9 hold clears FIFO", v, exp_snd(0, 0, 0));

    // R12 read data holds
    rd(4'hD, v);
    sec_rd_data = ~sec_rd_data; repeat (3) @(negedge clk);
    chk("R12 rdata holds", bus_rdata, v);

    // R2 unlock, R3 translation
    wr(4'h4, 16'h1234); wr(4'hF, 16'h0081);
    wr(4'h0, 16'h00E1);
    rd(4'h4, v); chk("R2 non-code write keeps linear", v, 16'h1234);
    wr(4'h0, 16'h00E2); m_perm = 1; m_regs[4] = 0; m_regs[15] = 0;
    rd(4'hF, v); chk("R2 enable cleared", v, 16'h0);
    rd(4'h4, v); chk("R2 scratch cleared", v, 16'h0);
    in_ports = {$urandom, $urandom};
    rd(4'h0, v); chk("R4 port0 raw when translated", v, in_ports[15:0]);
    m_perm = 0;
    rd(4'hB, v); chk("R3 bus offset 11 reaches reg 0", v, in_ports[15:0]);
    rd(4'h0, v); chk("R3 bus offset 0 reaches reg 4", v, 16'h0);
    m_perm = 1;
    for (int k = 0; k < 16; k++) begin
      logic [3:0] a;
      logic [15:0] d;
      a = (k % 2 == 0) ? 4'h5 : 4'hC;
      d = 16'($urandom);
      wr(a, d); m_regs[a] = d;
      rd(a, v); chk("R3 translated readback", v, m_regs[a]);
    end
    wr(4'h0, 16'h00E2);
    rd(4'h0, v); chk("R2 permutation stays on", v, in_ports[15:0]);

    // R1 reset turns translation off again
    @(negedge clk); rst = 1; repeat (2) @(negedge clk); rst = 0; m_perm = 0;
    rd(4'h0, v); chk("R1 linear after reset", v, (in_ports[15:0] & 16'h1FFE) | 16'h2001);

    finish_run();
  end
endmodule